// File: doc/BRIEF.md
# Event Interrupt Controller

This block sits beside a processor core and gathers interrupt events from peripheral and external request lines. Each line passes through a two-flop synchronizer. A rising edge on the synchronized line latches a pending flag for that source. Each source also has its own enable bit and a programmable 4-bit urgency level. A global enable bit gates every source at once.

On each clock the block picks the enabled pending source with the highest level, taking the lowest index when levels are equal. It raises a registered request to the core, with the winning index, only when that level is strictly above the level of the code now running, which the core supplies. The core answers with a one-cycle acknowledge. The acknowledge clears the winner's flag, and the core then reports its new running level.

Software reaches the control, enable, pending and level registers through a plain write strobe and a registered read port.

Top module: `evt_irq_ctrl`

## Requirements
- R1: After a synchronous reset, every pending flag, enable bit, level and the global enable are zero, `irq_req` and `irq_id` are zero, and every register reads back as 0.
- R2: A rising edge on `evt_pin[i]` sets pending flag i on the third clock edge after the pin goes high. The flag sets whatever the state of that source's enable bit and of the global enable.
- R3: The global enable is bit 0 of the control register at address 0. While it is clear, `irq_req` stays low.
- R4: Bit i of the enable register at address 1 masks source i on its own. A masked source never wins arbitration.
- R5: A flag that was latched while its source was masked raises a request once the source (and the global enable) is switched on.
- R6: The level of source 2k sits in bits [3:0] of address 4+k, and the level of source 2k+1 in bits [7:4]. Every level register reads back what was written.
- R7: A request is raised only when the winner's level is strictly greater than `run_level`. A source at level 0 therefore never raises a request.
- R8: Among enabled pending sources the highest level wins. On equal levels the lowest source index wins.
- R9: `irq_req` and `irq_id` are registered and follow their inputs one clock edge later. An `irq_ack` clears flag `irq_id` at that edge and forces `irq_req` low after it.
- R10: If a new edge on a source and an acknowledge of that same source land on the same clock edge, the flag stays set.
- R11: The pending flags read at address 2, with bit i for source i. Writes to that address are ignored. A read returns data one clock edge after the address is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_pin | input | N_SRC | Asynchronous event request lines, one per source |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | AW | Register address |
| reg_wdata | input | DATA_W | Register write data |
| reg_rdata | output | DATA_W | Registered read data for the address presented one edge earlier |
| run_level | input | LVL_W | Level of the code the core is running now |
| irq_ack | input | 1 | One-cycle acknowledge of the current request |
| irq_req | output | 1 | Interrupt request to the core |
| irq_id | output | IW | Index of the requesting source |

## Verification
The results of this block appear at fixed delays:
- A pin edge appears in the pending register on the third edge after the pin rises, and in `irq_req` on the fourth.
- A register write or a `run_level` change takes effect at the next edge and appears in `irq_req` one edge after that.
- An acknowledge drops `irq_req` at its own edge.
- Read data appears one edge after the address.

The bench drives inputs at falling edges and waits at least those edge counts before it samples at a later falling edge. Its model flags are updated only once the latching edge has passed. The same-edge set-and-clear case is placed by counting edges exactly.

// File: rtl/evt_irq_pkg.sv
package evt_irq_pkg;
  localparam int ADDR_CTRL = 0;
  localparam int ADDR_EN   = 1;
  localparam int ADDR_PEND = 2;
  localparam int PRI_BASE  = 4;
endpackage

// File: rtl/evt_irq_sync.sv
module evt_irq_sync #(
  parameter int N_SRC = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N_SRC-1:0] pin,
  output logic [N_SRC-1:0] rise
);
  logic [N_SRC-1:0] s1_q, s2_q, s3_q;

  for (genvar i = 0; i < N_SRC; i++) begin : g_line
    always_ff @(posedge clk) begin
      if (rst) begin
        s1_q[i] <= 1'b0;
        s2_q[i] <= 1'b0;
        s3_q[i] <= 1'b0;
      end else begin
        s1_q[i] <= pin[i];
        s2_q[i] <= s1_q[i];
        s3_q[i] <= s2_q[i];
      end
    end
    assign rise[i] = s2_q[i] & ~s3_q[i];
  end
endmodule

// File: rtl/evt_irq_regs.sv
module evt_irq_regs
  import evt_irq_pkg::*;
#(
  parameter int N_SRC  = 8,
  parameter int LVL_W  = 4,
  parameter int DATA_W = 8,
  parameter int AW     = 3
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   we,
  input  logic [AW-1:0]          addr,
  input  logic [DATA_W-1:0]      wdata,
  input  logic [N_SRC-1:0]       pend,
  output logic [DATA_W-1:0]      rdata,
  output logic                   gie,
  output logic [N_SRC-1:0]       en,
  output logic [N_SRC*LVL_W-1:0] lvl_flat
);
  localparam int PER_REG = DATA_W / LVL_W;
  localparam int N_PRI   = N_SRC / PER_REG;

  logic [DATA_W-1:0] pri_q [N_PRI];
  logic [DATA_W-1:0] rd_next;

  always_ff @(posedge clk) begin
    if (rst) begin
      gie <= 1'b0;
      en  <= '0;
    end else if (we) begin
      if (addr == AW'(ADDR_CTRL)) gie <= wdata[0];
      if (addr == AW'(ADDR_EN))   en  <= wdata[N_SRC-1:0];
    end
  end

  for (genvar k = 0; k < N_PRI; k++) begin : g_pri
    localparam logic [AW-1:0] A = AW'(PRI_BASE + k);
    always_ff @(posedge clk) begin
      if (rst)                   pri_q[k] <= '0;
      else if (we && addr == A)  pri_q[k] <= wdata;
    end
    assign lvl_flat[k*DATA_W +: DATA_W] = pri_q[k];
  end

  always_comb begin
    rd_next = '0;
    if (addr == AW'(ADDR_CTRL)) rd_next = DATA_W'(gie);
    if (addr == AW'(ADDR_EN))   rd_next = DATA_W'(en);
    if (addr == AW'(ADDR_PEND)) rd_next = DATA_W'(pend);
    for (int k = 0; k < N_PRI; k++)
      if (addr == AW'(PRI_BASE + k)) rd_next = pri_q[k];
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= rd_next;
  end
endmodule

// File: rtl/evt_irq_arb.sv
module evt_irq_arb #(
  parameter int N_SRC = 8,
  parameter int LVL_W = 4,
  parameter int IW    = 3
) (
  input  logic [N_SRC-1:0]       pend,
  input  logic [N_SRC*LVL_W-1:0] lvl_flat,
  output logic                   valid,
  output logic [IW-1:0]          id,
  output logic [LVL_W-1:0]       lvl
);
  always_comb begin
    valid = 1'b0;
    id    = '0;
    lvl   = '0;
    for (int i = 0; i < N_SRC; i++) begin
      if (pend[i] && lvl_flat[i*LVL_W +: LVL_W] > lvl) begin
        valid = 1'b1;
        id    = IW'(i);
        lvl   = lvl_flat[i*LVL_W +: LVL_W];
      end
    end
  end
endmodule

// File: rtl/evt_irq_ctrl.sv
module evt_irq_ctrl
  import evt_irq_pkg::*;
#(
  parameter int N_SRC  = 8,
  parameter int LVL_W  = 4,
  parameter int DATA_W = 8,
  localparam int IW    = $clog2(N_SRC),
  localparam int AW    = $clog2(PRI_BASE + N_SRC * LVL_W / DATA_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [N_SRC-1:0]  evt_pin,
  input  logic              reg_we,
  input  logic [AW-1:0]     reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic [LVL_W-1:0]  run_level,
  input  logic              irq_ack,
  output logic              irq_req,
  output logic [IW-1:0]     irq_id
);
  logic [N_SRC-1:0]       rise, flag_q, clr, en;
  logic [N_SRC*LVL_W-1:0] lvl_flat;
  logic                   gie, win_valid;
  logic [IW-1:0]          win_id;
  logic [LVL_W-1:0]       win_lvl;

  evt_irq_sync #(.N_SRC(N_SRC)) sync_i (
    .clk(clk), .rst(rst), .pin(evt_pin), .rise(rise));

  evt_irq_regs #(.N_SRC(N_SRC), .LVL_W(LVL_W), .DATA_W(DATA_W), .AW(AW)) regs_i (
    .clk(clk), .rst(rst), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
    .pend(flag_q), .rdata(reg_rdata), .gie(gie), .en(en), .lvl_flat(lvl_flat));

  evt_irq_arb #(.N_SRC(N_SRC), .LVL_W(LVL_W), .IW(IW)) arb_i (
    .pend(flag_q & en & {N_SRC{gie}}), .lvl_flat(lvl_flat),
    .valid(win_valid), .id(win_id), .lvl(win_lvl));

  assign clr = irq_ack ? ({{(N_SRC-1){1'b0}}, 1'b1} << irq_id) : '0;

  always_ff @(posedge clk) begin
    if (rst) flag_q <= '0;
    else     flag_q <= (flag_q & ~clr) | rise;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_req <= 1'b0;
      irq_id  <= '0;
    end else begin
      irq_req <= !irq_ack && win_valid && (win_lvl > run_level);
      irq_id  <= win_id;
    end
  end

  assert_strict_level_R7: assert property (@(posedge clk) disable iff (rst)
    irq_req |-> ($past(win_lvl) > $past(run_level)));
  assert_global_gate_R3: assert property (@(posedge clk) disable iff (rst)
    !gie |=> !irq_req);
  assert_ack_drops_req_R9: assert property (@(posedge clk) disable iff (rst)
    irq_ack |=> !irq_req);
  assert_ack_clears_flag_R9: assert property (@(posedge clk) disable iff (rst)
    (irq_ack && !rise[irq_id]) |=> !flag_q[$past(irq_id)]);
  assert_set_holds_R10: assert property (@(posedge clk) disable iff (rst)
    (|rise) |=> ((flag_q & $past(rise)) == $past(rise)));
endmodule

// File: tb/evt_irq_ctrl_tb_top.sv
`timescale 1ns/1ps
module evt_irq_ctrl_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] evt_pin = '0;
  logic       reg_we = 1'b0;
  logic [2:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic [3:0] run_level = '0;
  logic       irq_ack = 1'b0;
  logic       irq_req;
  logic [2:0] irq_id;

  int n_chk = 0, n_fail = 0;
  logic [7:0] m_flag = '0, m_en = '0;
  logic       m_gie = 1'b0;
  logic [3:0] m_pri [8];

  always #2 clk = ~clk;

  evt_irq_ctrl dut_i (.clk(clk), .rst(rst), .evt_pin(evt_pin), .reg_we(reg_we),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .run_level(run_level), .irq_ack(irq_ack), .irq_req(irq_req), .irq_id(irq_id));

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic void model_arb(output bit r, output int id);
    int best = 0;
    r = 0; id = 0;
    for (int i = 0; i < 8; i++)
      if (m_gie && m_flag[i] && m_en[i] && int'(m_pri[i]) > best) begin
        best = int'(m_pri[i]); id = i;
      end
    r = (best > int'(run_level));
  endfunction

  task automatic wr(input int a, input int d);
    @(negedge clk); reg_we = 1'b1; reg_addr = 3'(a); reg_wdata = 8'(d);
    @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic rd(input int a, output int d);
    @(negedge clk); reg_addr = 3'(a);
    @(negedge clk); d = int'(reg_rdata);
  endtask

  task automatic set_en(input int v);   wr(1, v); m_en = 8'(v); endtask
  task automatic set_gie(input bit v);  wr(0, int'(v)); m_gie = v; endtask
  task automatic set_pri(input int s, input int l);
    m_pri[s] = 4'(l);
    wr(4 + s/2, {m_pri[(s/2)*2+1], m_pri[(s/2)*2]});
  endtask

  task automatic pulse(input int mask);
    @(negedge clk); evt_pin = 8'(mask);
    @(negedge clk); evt_pin = '0;
    repeat (3) @(negedge clk);
    m_flag |= 8'(mask);
  endtask

  task automatic settle_check(input string tag);
    bit r; int id;
    repeat (2) @(negedge clk);
    model_arb(r, id);
    check({tag, " irq_req"}, int'(irq_req), int'(r));
    if (r) check({tag, " irq_id"}, int'(irq_id), id);
  endtask

  task automatic do_ack(input string tag);
    int id = int'(irq_id);
    irq_ack = 1'b1;
    @(negedge clk); irq_ack = 1'b0;
    m_flag[id] = 1'b0;
    check({tag, " irq_req low after ack"}, int'(irq_req), 0);
  endtask

  initial begin
    int d;
    bit r; int id;
    void'($urandom(32'h5EED_1234));
    for (int i = 0; i < 8; i++) m_pri[i] = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    check("R1 irq_req", int'(irq_req), 0);
    check("R1 irq_id", int'(irq_id), 0);
    for (int a = 0; a < 8; a++) begin
      rd(a, d); check($sformatf("R1 reg %0d", a), d, 0);
    end
    // R2 flags latch while masked, R3/R4 nothing requested
    pulse(8'h05);
    settle_check("R2 R3 masked");
    rd(2, d); check("R2 R11 pending", d, 8'h05);
    wr(2, 8'hFF);
    rd(2, d); check("R11 pending write ignored", d, 8'h05);
    // R6 level layout
    set_pri(0, 3); set_pri(2, 3);
    rd(4, d); check("R6 addr4", d, 8'h03);
    rd(5, d); check("R6 addr5", d, 8'h03);
    set_pri(7, 9);
    rd(7, d); check("R6 addr7", d, 8'h90);
    set_en(8'h05);
    settle_check("R3 gie off");
    set_gie(1'b1);
    settle_check("R5 R8 tie lowest index");
    check("R8 tie id", int'(irq_id), 0);
    @(negedge clk); run_level = 4'd3;
    settle_check("R7 equal level");
    check("R7 equal level no req", int'(irq_req), 0);
    @(negedge clk); run_level = 4'd2;
    settle_check("R7 above level");
    do_ack("R9");
    settle_check("R9 next winner");
    check("R9 next id", int'(irq_id), 2);
    @(negedge clk); run_level = 4'd0;
    set_pri(2, 0);
    settle_check("R7 level zero");
    check("R7 level zero no req", int'(irq_req), 0);
    set_pri(2, 5);
    settle_check("R8 higher level");
    check("R10 setup", int'(irq_req), 1);
    // R10: new edge on source 2 lands on the ack edge
    @(negedge clk); evt_pin = 8'h04;
    @(negedge clk); evt_pin = '0;
    @(negedge clk); irq_ack = 1'b1;
    @(negedge clk); irq_ack = 1'b0;
    check("R10 irq_req low after ack", int'(irq_req), 0);
    rd(2, d); check("R10 flag kept", d & 8'h04, 8'h04);
    settle_check("R10 re-request");
    check("R10 re-request id", int'(irq_id), 2);
    do_ack("R9 clean");
    // random phase
    for (int it = 0; it < 400; it++) begin
      case ($urandom_range(0, 5))
        0: set_en(int'($urandom_range(0, 255)));
        1: set_pri(int'($urandom_range(0, 7)), int'($urandom_range(0, 15)));
        2: set_gie($urandom_range(0, 3) != 0);
        3: pulse(int'($urandom_range(0, 255) & $urandom_range(0, 255)));
        4: begin @(negedge clk); run_level = 4'($urandom_range(0, 15)); end
        default: begin
          model_arb(r, id);
          if (r && irq_req) do_ack("R9 random");
        end
      endcase
      settle_check("R4 R7 R8 random");
      if (it % 16 == 0) begin
        rd(2, d); check("R2 random pending", d, int'(m_flag));
      end
    end
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule